// File: doc/BRIEF.md
# Loadable 64-bit Free-Running Up-Counter

This block keeps a 64-bit count that rises by one on every clock while its run flag is set. Other logic on the chip sees the live value on a dedicated output. Software reaches the counter through a small register bus. It can read or overwrite either 32-bit half of the count at any time, whether the counter is running or stopped. It can set or clear the run flag.

Each write to a count half is confirmed later through a sticky status flag, one flag per half. Software clears a flag by writing a one to its bit. To read the full count, software reads the upper half, then the lower half, then the upper half again, and it repeats the sequence when the two upper values differ. The whole count is held in one register, so a carry from the low half reaches the high half in the same update.

The bus carries a valid strobe, a write enable, a word address (the byte offset divided by 4) and 32-bit write data. Read data comes back one cycle after the request. The reset input asserts asynchronously and is released to the logic on a clock edge.

Top module: `wide_uptimer`

## Requirements
- R1: While the internal reset is active and right after it, the count, the run flag, both status flags and the read data are all zero.
- R2: The run flag is bit 8 of the control word at byte offset 0x240 (word 0x090). When it is 1, the count rises by exactly one per clock. When it is 0, the count holds. A write there updates only bit 8, and reading the control word returns the run flag in bit 8 with every other bit zero.
- R3: A read of byte offset 0x100 (word 0x040) returns count bits 31:0, and a read of 0x104 (word 0x041) returns bits 63:32. The value returned is the one held at the request edge, and it appears on the read data one cycle later. When no read is requested, the read data keeps its last value.
- R4: A write to word 0x040 replaces count bits 31:0 at the next edge and leaves bits 63:32 unchanged. If the counter would step in that same cycle, the load wins and the count does not step. Counting then continues from the loaded value.
- R5: A write to word 0x041 replaces count bits 63:32 in the same way and leaves bits 31:0 unchanged. The load also beats the step.
- R6: A carry out of bit 31 shows in bits 63:32 on the same edge that bits 31:0 wrap. A high/low/high read sequence therefore never sees a stale upper half.
- R7: The count wraps from 2^64-1 to 0 and keeps running.
- R8: The status word is at byte offset 0x110 (word 0x044). Bit 0 confirms a low-half write and bit 1 confirms a high-half write, and all other bits read zero. A flag rises one clock after the loaded value has taken effect. It stays set until it is cleared.
- R9: Writing a one to a status bit clears that bit, and writing a zero leaves it unchanged. If a clear and a new confirmation reach the same flag in the same cycle, the flag ends up set.
- R10: Unmapped addresses read as zero, and writes to them change nothing. The count output always equals the value that a low/high read would return.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Counter and bus clock |
| rst_n | input | 1 | Active-low reset; asserts asynchronously, released synchronously inside |
| bus_valid | input | 1 | Bus request strobe |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 10 | Word address (byte offset / 4) |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid the cycle after a read request |
| count_value | output | 64 | Live count for other blocks |

## Verification
The bench loads the low half to just below a carry and then reads high, low and high on consecutive cycles. A design that updated the halves on separate edges would return a torn 64-bit value there. It also loads a half while the counter is running. A design that let the step win over the load would show the loaded value plus one.

The status flag is read on the cycle right after a load and again one cycle later. A flag set too early, or never set, is caught by these two reads. A clear is written into the same cycle as a fresh confirmation, and a design that gave the clear priority would drop that confirmation. A count of all ones is run across the 2^64 wrap. Reads of unmapped words must return zero, and idle cycles must hold the read data, which catches a read port that floats or leaks values.

// File: rtl/wide_uptimer_pkg.sv
package wide_uptimer_pkg;
  localparam int BYTES_PER_WORD = 4;

  function automatic int byte_to_word(input int byte_ofs);
    return byte_ofs / BYTES_PER_WORD;
  endfunction
endpackage

// File: rtl/uptimer_bus_decode.sv
module uptimer_bus_decode
  import wide_uptimer_pkg::*;
#(
  parameter int ADDR_W   = 10,
  parameter int DW       = 32,
  parameter int NSEG     = 2,
  parameter int CNT_OFS  = 'h100,
  parameter int STAT_OFS = 'h110,
  parameter int CTRL_OFS = 'h240,
  parameter int RUN_BIT  = 8
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               valid,
  input  logic               we,
  input  logic [ADDR_W-1:0]  addr,
  input  logic [NSEG*DW-1:0] count,
  input  logic               run,
  input  logic [NSEG-1:0]    wstat,
  output logic [NSEG-1:0]    seg_ld,
  output logic               stat_wr,
  output logic               ctrl_wr,
  output logic [DW-1:0]      rdata
);
  localparam logic [ADDR_W-1:0] CNT_WA  = ADDR_W'(byte_to_word(CNT_OFS));
  localparam logic [ADDR_W-1:0] STAT_WA = ADDR_W'(byte_to_word(STAT_OFS));
  localparam logic [ADDR_W-1:0] CTRL_WA = ADDR_W'(byte_to_word(CTRL_OFS));

  logic [NSEG-1:0] seg_hit;
  logic            stat_hit;
  logic            ctrl_hit;
  logic            rd_req;
  logic            wr_req;
  logic [DW-1:0]   rd_val;
  logic [DW-1:0]   rdata_d;
  logic [DW-1:0]   rdata_q;

  for (genvar i = 0; i < NSEG; i++) begin : g_seg_hit
    localparam logic [ADDR_W-1:0] SEG_WA = CNT_WA + ADDR_W'(i);
    assign seg_hit[i] = (addr == SEG_WA);
  end

  assign stat_hit = (addr == STAT_WA);
  assign ctrl_hit = (addr == CTRL_WA);
  assign rd_req   = valid && !we;
  assign wr_req   = valid && we;

  assign seg_ld  = wr_req ? seg_hit : '0;
  assign stat_wr = wr_req && stat_hit;
  assign ctrl_wr = wr_req && ctrl_hit;

  always_comb begin
    rd_val = '0;
    for (int i = 0; i < NSEG; i++) begin
      if (seg_hit[i]) rd_val = count[i*DW +: DW];
    end
    if (stat_hit) rd_val[NSEG-1:0] = wstat;
    if (ctrl_hit) rd_val[RUN_BIT]  = run;
  end

  always_comb begin
    rdata_d = rdata_q;
    if (rd_req) rdata_d = rd_val;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rdata_q <= '0;
    else if (rd_req) rdata_q <= rdata_d;
  end

  assign rdata = rdata_q;

  // R3: read data only moves on a read request
  p_rdata_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !(valid && !we) |=> $stable(rdata));

  // R3: low-half read returns the count held at the request edge
  p_rd_low_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (valid && !we && addr == CNT_WA) |=> rdata == $past(count[DW-1:0]));

  // R10: a read of an unmapped word returns zero
  p_unmapped_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (valid && !we && !(|seg_hit) && !stat_hit && !ctrl_hit) |=> rdata == '0);
endmodule

// File: rtl/uptimer_counter.sv
module uptimer_counter #(
  parameter int DW   = 32,
  parameter int NSEG = 2
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               run,
  input  logic [NSEG-1:0]    seg_ld,
  input  logic [DW-1:0]      ld_data,
  output logic [NSEG*DW-1:0] count
);
  localparam int CW = NSEG * DW;

  logic          any_ld;
  logic          cnt_en;
  logic [CW-1:0] stepped;
  logic [CW-1:0] base;
  logic [CW-1:0] count_d;
  logic [CW-1:0] count_q;

  assign any_ld  = |seg_ld;
  assign cnt_en  = any_ld || run;
  assign stepped = count_q + CW'(1);

  always_comb begin
    base = count_q;
    if (!any_ld && run) base = stepped;
  end

  for (genvar i = 0; i < NSEG; i++) begin : g_seg_next
    assign count_d[i*DW +: DW] = seg_ld[i] ? ld_data : base[i*DW +: DW];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) count_q <= '0;
    else if (cnt_en) count_q <= count_d;
  end

  assign count = count_q;

  // R2: stopped and no load -> hold
  p_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (!run && !(|seg_ld)) |=> $stable(count_q));

  // R2 / R6: running and no load -> +1 across the full width
  p_step_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (run && !(|seg_ld)) |=> count_q == $past(count_q) + CW'(1));

  // R7: all-ones wraps to zero
  p_wrap_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (run && !(|seg_ld) && (&count_q)) |=> count_q == '0);

  for (genvar i = 0; i < NSEG; i++) begin : g_ld_chk
    // R4 (segment 0) and R5 (segment 1): load lands and beats the step
    p_load_seg_r4: assert property (@(posedge clk) disable iff (!rst_n)
      seg_ld[i] |=> count_q[i*DW +: DW] == $past(ld_data));
  end
endmodule

// File: rtl/uptimer_wstat.sv
module uptimer_wstat #(
  parameter int NSEG = 2
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [NSEG-1:0] seg_ld,
  input  logic            stat_wr,
  input  logic [NSEG-1:0] clr_mask,
  output logic [NSEG-1:0] wstat
);
  logic [NSEG-1:0] pend_q;
  logic [NSEG-1:0] clr_vec;
  logic [NSEG-1:0] wstat_d;
  logic [NSEG-1:0] wstat_q;
  logic            wstat_en;

  assign clr_vec  = stat_wr ? clr_mask : '0;
  assign wstat_en = stat_wr || (|pend_q);

  for (genvar i = 0; i < NSEG; i++) begin : g_flag_next
    assign wstat_d[i] = pend_q[i] | (wstat_q[i] & ~clr_vec[i]);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pend_q <= '0;
    else pend_q <= seg_ld;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) wstat_q <= '0;
    else if (wstat_en) wstat_q <= wstat_d;
  end

  assign wstat = wstat_q;

  for (genvar i = 0; i < NSEG; i++) begin : g_flag_chk
    // R8: confirmation two edges after the load request
    p_set_late_r8: assert property (@(posedge clk) disable iff (!rst_n)
      seg_ld[i] |=> ##1 wstat_q[i]);
    // R9: a one clears when no confirmation is pending
    p_clear_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (stat_wr && clr_mask[i] && !pend_q[i]) |=> !wstat_q[i]);
    // R9: without a clear, a set flag stays set
    p_sticky_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (wstat_q[i] && !(stat_wr && clr_mask[i])) |=> wstat_q[i]);
  end
endmodule

// File: rtl/wide_uptimer.sv
module wide_uptimer
  import wide_uptimer_pkg::*;
#(
  parameter int CNT_W    = 64,
  parameter int DATA_W   = 32,
  parameter int ADDR_W   = 10,
  parameter int CNT_OFS  = 'h100,
  parameter int STAT_OFS = 'h110,
  parameter int CTRL_OFS = 'h240,
  parameter int RUN_BIT  = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_valid,
  input  logic              bus_we,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  output logic [CNT_W-1:0]  count_value
);
  localparam int NSEG = CNT_W / DATA_W;

  logic [1:0]       rst_sync_q;
  logic             rst_int_n;
  logic [NSEG-1:0]  seg_ld;
  logic             stat_wr;
  logic             ctrl_wr;
  logic             run_d;
  logic             run_q;
  logic [NSEG-1:0]  wstat;
  logic [CNT_W-1:0] count;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= '0;
    else rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_int_n = rst_sync_q[1];

  always_comb begin
    run_d = run_q;
    if (ctrl_wr) run_d = bus_wdata[RUN_BIT];
  end

  always_ff @(posedge clk or negedge rst_int_n) begin
    if (!rst_int_n) run_q <= 1'b0;
    else if (ctrl_wr) run_q <= run_d;
  end

  uptimer_bus_decode #(
    .ADDR_W(ADDR_W), .DW(DATA_W), .NSEG(NSEG), .CNT_OFS(CNT_OFS),
    .STAT_OFS(STAT_OFS), .CTRL_OFS(CTRL_OFS), .RUN_BIT(RUN_BIT)
  ) u_decode (
    .clk(clk), .rst_n(rst_int_n), .valid(bus_valid), .we(bus_we),
    .addr(bus_addr), .count(count), .run(run_q), .wstat(wstat),
    .seg_ld(seg_ld), .stat_wr(stat_wr), .ctrl_wr(ctrl_wr), .rdata(bus_rdata)
  );

  uptimer_counter #(.DW(DATA_W), .NSEG(NSEG)) u_counter (
    .clk(clk), .rst_n(rst_int_n), .run(run_q), .seg_ld(seg_ld),
    .ld_data(bus_wdata), .count(count)
  );

  uptimer_wstat #(.NSEG(NSEG)) u_wstat (
    .clk(clk), .rst_n(rst_int_n), .seg_ld(seg_ld), .stat_wr(stat_wr),
    .clr_mask(bus_wdata[NSEG-1:0]), .wstat(wstat)
  );

  assign count_value = count;

  // R2: control write sets the run flag from bit RUN_BIT
  p_run_ctl_r2: assert property (@(posedge clk) disable iff (!rst_int_n)
    ctrl_wr |=> run_q == $past(bus_wdata[RUN_BIT]));

  // R1: while reset is held, the exported count is zero
  p_reset_zero_r1: assert property (@(posedge clk)
    !rst_int_n |-> count_value == '0);
endmodule

// File: tb/wide_uptimer_test.sv
module wide_uptimer_test;
  localparam logic [9:0] A_LO = 10'h040;
  localparam logic [9:0] A_HI = 10'h041;
  localparam logic [9:0] A_ST = 10'h044;
  localparam logic [9:0] A_CT = 10'h090;

  typedef struct {
    int          due;
    logic [31:0] exp;
    string       req;
  } sb_item_t;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_valid = 1'b0;
  logic        bus_we = 1'b0;
  logic [9:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic [63:0] count_value;

  logic [63:0] m_cnt;
  logic        m_run;
  logic [1:0]  m_ws;
  logic [1:0]  m_pend;
  logic [31:0] last_exp = '0;
  int          cyc = 0;
  int          n_cmp = 0;
  int          n_bad = 0;
  bit          live = 1'b0;
  bit          done = 1'b0;
  sb_item_t    sbq[$];
  sb_item_t    cur;

  wide_uptimer uut (
    .clk(clk), .rst_n(rst_n), .bus_valid(bus_valid), .bus_we(bus_we),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .count_value(count_value)
  );

  always #5 clk = ~clk;

  always @(posedge clk) cyc <= cyc + 1;

  wire w_lo = bus_valid && bus_we && bus_addr == A_LO;
  wire w_hi = bus_valid && bus_we && bus_addr == A_HI;
  wire w_st = bus_valid && bus_we && bus_addr == A_ST;
  wire w_ct = bus_valid && bus_we && bus_addr == A_CT;

  // reference model built from the requirements
  always @(posedge clk) begin
    if (!rst_n) begin
      m_cnt <= '0; m_run <= 1'b0; m_ws <= '0; m_pend <= '0;
    end else begin
      m_pend <= {w_hi, w_lo};
      m_ws   <= m_pend | (m_ws & ~({2{w_st}} & bus_wdata[1:0]));
      if (w_lo)       m_cnt <= {m_cnt[63:32], bus_wdata};
      else if (w_hi)  m_cnt <= {bus_wdata, m_cnt[31:0]};
      else if (m_run) m_cnt <= m_cnt + 64'd1;
      if (w_ct) m_run <= bus_wdata[8];
    end
  end

  function automatic logic [31:0] model_read(input logic [9:0] a);
    case (a)
      A_LO:    return m_cnt[31:0];
      A_HI:    return m_cnt[63:32];
      A_ST:    return {30'd0, m_ws};
      A_CT:    return {23'd0, m_run, 8'd0};
      default: return 32'd0;
    endcase
  endfunction

  task automatic cmp(input string req, input logic [63:0] act, input logic [63:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h (cycle %0d)", req, act, exp, cyc);
    end
  endtask

  // monitor: compare as results appear
  always @(negedge clk) begin
    if (live) cmp("R10 live count", count_value, m_cnt);
    while (sbq.size() > 0 && sbq[0].due == cyc) begin
      cur = sbq.pop_front();
      cmp(cur.req, {32'd0, bus_rdata}, {32'd0, cur.exp});
    end
  end

  task automatic push(input logic [31:0] e, input string req);
    sb_item_t it;
    it.due = cyc + 1;
    it.exp = e;
    it.req = req;
    sbq.push_back(it);
    last_exp = e;
  endtask

  task automatic rd(input logic [9:0] a, input string req);
    @(negedge clk);
    bus_valid = 1'b1; bus_we = 1'b0; bus_addr = a; bus_wdata = 32'h5A5A_5A5A;
    push(model_read(a), req);
  endtask

  task automatic wr(input logic [9:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_valid = 1'b1; bus_we = 1'b1; bus_addr = a; bus_wdata = d;
    push(last_exp, "R3 hold on write");
  endtask

  task automatic idle(input int n);
    for (int k = 0; k < n; k++) begin
      @(negedge clk);
      bus_valid = 1'b0; bus_we = 1'b0; bus_addr = A_LO; bus_wdata = 32'hFFFF_FFFF;
      push(last_exp, "R3 hold when idle");
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  endtask

  initial begin
    repeat (60000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog expired (cycle %0d)", cyc);
    finish_run();
  end

  initial begin
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    live = 1'b1;
    idle(4);
    // R1: everything reads zero after reset
    rd(A_LO, "R1 reset low"); rd(A_HI, "R1 reset high");
    rd(A_ST, "R1 reset status"); rd(A_CT, "R1 reset control");
    // R2: stopped counter holds
    idle(6); rd(A_LO, "R2 stopped hold");
    // R2: start with junk in other bits, run, read control back
    wr(A_CT, 32'hFFFF_FFFF); idle(9);
    rd(A_CT, "R2 control readback"); rd(A_LO, "R2 running low");
    // R4: load low half while running, then R8 status timing
    wr(A_LO, 32'h0000_1000);
    rd(A_ST, "R8 status not yet set");
    rd(A_ST, "R8 status set after load");
    rd(A_LO, "R4 low loaded and counting");
    // R9: writing zero keeps, one clears
    wr(A_ST, 32'h0000_0000); rd(A_ST, "R9 zero write keeps");
    wr(A_ST, 32'h0000_0001); rd(A_ST, "R9 one write clears");
    // R5: load high half while running
    wr(A_HI, 32'h0000_ABCD);
    rd(A_HI, "R5 high loaded"); rd(A_LO, "R5 low untouched");
    rd(A_ST, "R8 high flag set"); wr(A_ST, 32'h0000_0002);
    rd(A_ST, "R9 high flag cleared");
    // R9: confirmation and clear in the same cycle -> set wins
    wr(A_LO, 32'h0000_0020); wr(A_ST, 32'h0000_0003);
    rd(A_ST, "R9 set beats clear");
    wr(A_ST, 32'h0000_0003); rd(A_ST, "R9 cleared afterwards");
    // R6: carry across halves, loaded while stopped
    wr(A_CT, 32'h0000_0000);
    wr(A_LO, 32'hFFFF_FFFC); wr(A_HI, 32'h0000_0007);
    idle(3); rd(A_LO, "R4 load while stopped");
    wr(A_CT, 32'h0000_0100);
    for (int k = 0; k < 4; k++) begin
      rd(A_HI, "R6 high before low"); rd(A_LO, "R6 low");
      rd(A_HI, "R6 high after low");
    end
    // R7: wrap at 2^64
    wr(A_CT, 32'h0000_0000);
    wr(A_LO, 32'hFFFF_FFFE); wr(A_HI, 32'hFFFF_FFFF);
    wr(A_CT, 32'h0000_0100);
    rd(A_LO, "R7 low near wrap"); rd(A_HI, "R7 high near wrap");
    rd(A_LO, "R7 low after wrap"); rd(A_HI, "R7 high after wrap");
    // R10: unmapped space
    wr(A_ST, 32'h0000_0003);
    wr(10'h3FF, 32'hFFFF_FFFF); wr(10'h042, 32'h1234_5678);
    rd(10'h3FF, "R10 unmapped read"); rd(10'h042, "R10 gap read");
    rd(A_ST, "R10 unmapped write leaves status");
    rd(A_CT, "R10 unmapped write leaves run");
    rd(A_HI, "R10 unmapped write leaves high");
    // R2: stop freezes the count
    wr(A_CT, 32'hFFFF_FEFF); idle(5);
    rd(A_LO, "R2 frozen low"); idle(3);
    rd(A_LO, "R2 still frozen");
    idle(4);
    finish_run();
  end
endmodule